// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This controller gathers level-sensitive interrupt lines from many peripherals and presents them to a processor as one interrupt request and a numeric vector. The sources are grouped into banks of 32, and each bank has three registers: one with a sticky pending flag per line, one with a per-line enable, and one with a per-line mask. A source takes part in arbitration when its pending flag is set, its enable bit is one and its mask bit is zero. Among the sources that take part, the lowest-numbered one from 1 upward wins.

Software uses a small word-addressed register bus. The interrupt handler reads the vector register and services the reported source. It then acknowledges the source by writing a one to that source's pending bit, and reads the vector again. It repeats this until the vector reads zero. Source 0 can never win, so a vector of zero always means that no source is active.

A protection bit can lock the enable, mask and external-trigger-type registers against writes that are not privileged. The fast-interrupt pending window is present in the address map, but it holds no state.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every pending, enable and mask bit, the protection bit and the trigger-type field are zero. The vector reads 0 and `cpu_irq` is low.
- R2: Source n is bank n/32, bit n%32. Pending bank b is at byte offset 0x10+4b, enable bank b at 0x40+4b and mask bank b at 0x50+4b, for b = 0, 1, 2. Any offset with bits [1:0] not zero, or that is not listed in these requirements, reads 0 and ignores writes.
- R3: A pending bit is set at every rising clock edge at which its source line is high. It stays set after the line falls.
- R4: On a write to a pending register, each data bit that is 1 clears the matching pending bit, and each 0 bit leaves it unchanged. If the source line is high at that same edge, the bit stays set.
- R5: Enable and mask registers read back exactly the 32-bit value last accepted for them.
- R6: The vector register at offset 0x00 returns, in bits [8:2], the lowest source number in the range 1..95 that is pending, enabled and not masked. All other bits are zero. When no such source exists the register reads 0. Source 0 is never reported.
- R7: `cpu_irq` is high exactly when the vector register would read non-zero.
- R8: Register reads are combinational. A read issued in the cycle after an acknowledge edge already shows the next winning source.
- R9: A mask bit of 1, or an enable bit of 0, keeps a pending source out of both the vector and `cpu_irq`.
- R10: The protection bit is bit 0 at offset 0x08 and is writable at any time. While it is 1, writes to enable, mask or trigger-type registers with `bus_priv` low are ignored, and writes with `bus_priv` high are accepted.
- R11: The external trigger-type field is bits [1:0] at offset 0x0C. It reads back, its upper bits read 0, and 0 means level mode.
- R12: The fast-interrupt pending offsets 0x20, 0x24 and 0x28 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 96 | Level interrupt lines, bit n is source n |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Interrupt request toward the processor |

## Verification
A bad pending, enable or mask bit shows up in the very next combinational read of that bank. When it belongs to the winning source, it also shows up at once in the vector value and in `cpu_irq`. A clear that fails to take effect, or a lost priority ordering, appears as a wrong vector in the read right after the acknowledge edge. A protection leak appears as an enable or mask readback that differs from the value held before the blocked write.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // register window selected by a bus offset
    typedef enum logic [2:0] {
        RG_NONE,
        RG_VEC,
        RG_PROT,
        RG_NMI,
        RG_PEND,
        RG_FIQ,
        RG_EN,
        RG_MASK
    } reg_sel_e;

    localparam logic [3:0] GRP_CTRL = 4'h0;
    localparam logic [3:0] GRP_PEND = 4'h1;
    localparam logic [3:0] GRP_FIQ  = 4'h2;
    localparam logic [3:0] GRP_EN   = 4'h4;
    localparam logic [3:0] GRP_MASK = 4'h5;

    // word slot inside the control group
    localparam logic [1:0] SLOT_VEC  = 2'd0;
    localparam logic [1:0] SLOT_PROT = 2'd2;
    localparam logic [1:0] SLOT_NMI  = 2'd3;

    function automatic reg_sel_e decode_region(input logic [7:0] addr);
        reg_sel_e r;
        r = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (addr[7:4])
                GRP_CTRL: begin
                    if (addr[3:2] == SLOT_VEC)       r = RG_VEC;
                    else if (addr[3:2] == SLOT_PROT) r = RG_PROT;
                    else if (addr[3:2] == SLOT_NMI)  r = RG_NMI;
                end
                GRP_PEND: r = RG_PEND;
                GRP_FIQ:  r = RG_FIQ;
                GRP_EN:   r = RG_EN;
                GRP_MASK: r = RG_MASK;
                default:  r = RG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] wdata,
    input  logic         pend_we,
    input  logic         en_we,
    input  logic         mask_we,
    output logic [W-1:0] pend,
    output logic [W-1:0] en,
    output logic [W-1:0] mask
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic [W-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = pend_we ? wdata : '0;
        // level re-asserts after the clear in the same edge
        st_d.pend = (st_q.pend & ~clr_vec) | src;
        if (en_we) begin
            st_d.en = wdata;
        end
        if (mask_we) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign en   = st_q.en;
    assign mask = st_q.mask;

endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
    parameter int N  = 96,
    parameter int IW = 7
) (
    input  logic [N-1:1]  act,
    output logic [IW-1:0] idx,
    output logic          valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        // scan downward so the lowest active line is the last written
        for (int i = N - 1; i >= 1; i--) begin
            if (act[i]) begin
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int NMI_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] src_lvl,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    input  logic                        bus_priv,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        cpu_irq
);

    localparam int NSRC  = NUM_BANKS * BANK_W;
    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic             prot;
        logic [NMI_W-1:0] nmi;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    reg_sel_e    region;
    logic [1:0]  bank_sel;
    logic        bank_ok;
    logic        wr_cyc;
    logic        wr_ok;

    logic [NSRC-1:0]  pend_all;
    logic [NSRC-1:0]  en_all;
    logic [NSRC-1:0]  mask_all;
    logic [NSRC-1:1]  act;
    logic [IDX_W-1:0] vec_idx;
    logic             vec_valid;

    // access decode
    always_comb begin
        region   = decode_region(bus_addr);
        bank_sel = bus_addr[3:2];
        bank_ok  = (int'(bank_sel) < NUM_BANKS);
        wr_cyc   = bus_sel && bus_wr;
        wr_ok    = !ctl_q.prot || bus_priv;
    end

    // control state next value
    always_comb begin
        ctl_d = ctl_q;
        if (wr_cyc && region == RG_PROT) begin
            ctl_d.prot = bus_wdata[0];
        end
        if (wr_cyc && wr_ok && region == RG_NMI) begin
            ctl_d.nmi = bus_wdata[NMI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // one register bank per group of source lines
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic pend_we;
        logic en_we;
        logic mask_we;

        assign hit     = wr_cyc && bank_ok && (bank_sel == 2'(b));
        assign pend_we = hit && (region == RG_PEND);
        assign en_we   = hit && wr_ok && (region == RG_EN);
        assign mask_we = hit && wr_ok && (region == RG_MASK);

        irq_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_lvl[b*BANK_W +: BANK_W]),
            .wdata   (bus_wdata),
            .pend_we (pend_we),
            .en_we   (en_we),
            .mask_we (mask_we),
            .pend    (pend_all[b*BANK_W +: BANK_W]),
            .en      (en_all[b*BANK_W +: BANK_W]),
            .mask    (mask_all[b*BANK_W +: BANK_W])
        );
    end

    assign act = pend_all[NSRC-1:1] & en_all[NSRC-1:1] & ~mask_all[NSRC-1:1];

    irq_vec_enc #(.N(NSRC), .IW(IDX_W)) u_enc (
        .act   (act),
        .idx   (vec_idx),
        .valid (vec_valid)
    );

    assign cpu_irq = vec_valid;

    // read path
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            RG_VEC:  if (vec_valid) bus_rdata[IDX_W+1:2] = vec_idx;
            RG_PROT: bus_rdata[0] = ctl_q.prot;
            RG_NMI:  bus_rdata[NMI_W-1:0] = ctl_q.nmi;
            RG_PEND: if (bank_ok) bus_rdata = pend_all[int'(bank_sel)*BANK_W +: BANK_W];
            RG_EN:   if (bank_ok) bus_rdata = en_all[int'(bank_sel)*BANK_W +: BANK_W];
            RG_MASK: if (bank_ok) bus_rdata = mask_all[int'(bank_sel)*BANK_W +: BANK_W];
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int NSRC   = 96,
    parameter int IDX_W  = 7,
    parameter int BANK_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_lvl,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             bus_priv,
    input logic [BANK_W-1:0] bus_rdata,
    input logic             cpu_irq,
    input logic             prot,
    input logic [NSRC-1:0]  pend_all,
    input logic [NSRC-1:0]  en_all,
    input logic [NSRC-1:0]  mask_all,
    input logic [IDX_W-1:0] vec_idx,
    input logic             vec_valid
);

    logic [NSRC-1:0] live;
    logic [NSRC-1:0] below;
    logic            locked_en_wr;
    logic            fiq_rd;

    assign live         = pend_all & en_all & ~mask_all;
    assign below        = live & ((NSRC'(1) << vec_idx) - NSRC'(1));
    assign locked_en_wr = prot && bus_sel && bus_wr && !bus_priv
                          && (decode_region(bus_addr) == RG_EN);
    assign fiq_rd       = bus_sel && !bus_wr && (decode_region(bus_addr) == RG_FIQ);

    AST_PEND_CAPTURES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_all & $past(src_lvl)) == $past(src_lvl))); // R3

    AST_PEND_RISE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_all & ~$past(pend_all) & ~$past(src_lvl)) == '0)); // R4

    AST_VEC_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (live[vec_idx] && vec_idx != '0)); // R6

    AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (below[NSRC-1:1] == '0)); // R6

    AST_IRQ_LOW_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_irq |-> (live[NSRC-1:1] == '0)); // R7

    AST_LOCKED_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        locked_en_wr |=> $stable(en_all)); // R10

    AST_FIQ_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_rd |-> (bus_rdata == '0)); // R12

endmodule

bind banked_irq_ctrl irq_ctrl_chk #(
    .NSRC   (NSRC),
    .IDX_W  (IDX_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .prot      (ctl_q.prot),
    .pend_all  (pend_all),
    .en_all    (en_all),
    .mask_all  (mask_all),
    .vec_idx   (vec_idx),
    .vec_valid (vec_valid)
);

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_lvl = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [95:0] m_pend = '0;
    logic [95:0] m_en = '0;
    logic [95:0] m_mask = '0;
    logic        m_prot = 1'b0;
    logic [1:0]  m_nmi = '0;

    always #10 clk = ~clk; // 50 MHz

    banked_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl   (src_lvl),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_priv  (bus_priv),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    function automatic int win_src();
        int w;
        w = 0;
        for (int i = 95; i >= 1; i--) begin
            if (m_pend[i] && m_en[i] && !m_mask[i]) w = i;
        end
        return w;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int b;
        b = int'(a[3:2]);
        if (a[1:0] != 2'b00) return '0;
        case (a[7:4])
            4'h0: begin
                if (a[3:2] == 2'd0) return 32'(win_src()) << 2;
                if (a[3:2] == 2'd2) return {31'd0, m_prot};
                if (a[3:2] == 2'd3) return {30'd0, m_nmi};
                return '0;
            end
            4'h1: return (b < 3) ? m_pend[b*32 +: 32] : '0;
            4'h4: return (b < 3) ? m_en[b*32 +: 32] : '0;
            4'h5: return (b < 3) ? m_mask[b*32 +: 32] : '0;
            default: return '0;
        endcase
    endfunction

    // one clock with an optional write; inputs change at the falling edge
    task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d, input bit p);
        logic [95:0] clr;
        int b;
        bit ok;
        bus_sel   = w;
        bus_wr    = w;
        bus_addr  = a;
        bus_wdata = d;
        bus_priv  = p;
        @(posedge clk);
        clr = '0;
        b   = int'(a[3:2]);
        ok  = !m_prot || p;
        if (w && a[1:0] == 2'b00) begin
            if (a[7:4] == 4'h1 && b < 3) clr[b*32 +: 32] = d;
            if (a[7:4] == 4'h4 && b < 3 && ok) m_en[b*32 +: 32] = d;
            if (a[7:4] == 4'h5 && b < 3 && ok) m_mask[b*32 +: 32] = d;
            if (a == 8'h08) m_prot = d[0];
            if (a == 8'h0C && ok) m_nmi = d[1:0];
        end
        m_pend = (m_pend & ~clr) | src_lvl;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input string req);
        logic [31:0] e;
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        e = exp_rd(a);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, e);
        end
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input string req);
        logic e;
        #1;
        e = (win_src() != 0);
        checks++;
        if (cpu_irq !== e) begin
            errors++;
            $display("FAIL %s cpu_irq actual=%b expected=%b", req, cpu_irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [7:0] ADDRS [15] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
        8'h20, 8'h24, 8'h28, 8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58};

    initial begin
        logic [7:0] a;
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 15; i++) chk_rd(ADDRS[i], "R1");
        chk_irq("R1");

        // R3 / R2: source 37 pulses, bank 1 bit 5
        src_lvl[37] = 1'b1;
        cyc(0, 8'h00, 0, 0);
        src_lvl[37] = 1'b0;
        cyc(0, 8'h00, 0, 0);
        chk_rd(8'h14, "R3");
        chk_rd(8'h10, "R2");

        // R6 / R7: enabling makes it the vector
        cyc(1, 8'h44, 32'h0000_0020, 0);
        chk_rd(8'h00, "R6");
        chk_irq("R7");

        // R6: source 0 pending and enabled is never reported
        src_lvl[0] = 1'b1;
        cyc(1, 8'h40, 32'h0000_0001, 0);
        src_lvl[0] = 1'b0;
        cyc(1, 8'h14, 32'h0000_0020, 0);
        chk_rd(8'h00, "R6");
        chk_irq("R6");
        chk_rd(8'h10, "R6");

        // R4: write of zero keeps, clear while line high keeps
        src_lvl[70] = 1'b1;
        cyc(0, 8'h00, 0, 0);
        cyc(1, 8'h18, 32'h0, 0);
        chk_rd(8'h18, "R4");
        cyc(1, 8'h18, 32'hFFFF_FFFF, 0);
        chk_rd(8'h18, "R4");
        src_lvl[70] = 1'b0;

        // R8: acknowledge shows next winner on the following read
        src_lvl[40] = 1'b1;
        cyc(1, 8'h48, 32'h0000_0040, 0);
        cyc(1, 8'h44, 32'h0000_0100, 0);
        src_lvl[40] = 1'b0;
        chk_rd(8'h00, "R8");
        cyc(1, 8'h14, 32'h0000_0100, 0);
        chk_rd(8'h00, "R8");

        // R9: mask and enable block
        cyc(1, 8'h58, 32'h0000_0040, 0);
        chk_rd(8'h00, "R9");
        chk_irq("R9");
        cyc(1, 8'h58, 32'h0, 0);
        cyc(1, 8'h48, 32'h0, 0);
        chk_rd(8'h00, "R9");

        // R5 / R11 readback
        cyc(1, 8'h54, 32'hA5A5_0F0F, 0);
        chk_rd(8'h54, "R5");
        cyc(1, 8'h0C, 32'hFFFF_FFFE, 0);
        chk_rd(8'h0C, "R11");

        // R10: protection
        cyc(1, 8'h08, 32'h1, 0);
        chk_rd(8'h08, "R10");
        cyc(1, 8'h40, 32'h1234_5678, 0);
        chk_rd(8'h40, "R10");
        cyc(1, 8'h0C, 32'h1, 0);
        chk_rd(8'h0C, "R10");
        cyc(1, 8'h40, 32'h1234_5678, 1);
        chk_rd(8'h40, "R10");
        cyc(1, 8'h08, 32'h0, 0);

        // R12: fast-interrupt window
        cyc(1, 8'h24, 32'hFFFF_FFFF, 1);
        chk_rd(8'h24, "R12");
        // R2: misaligned write ignored
        cyc(1, 8'h41, 32'hFFFF_FFFF, 1);
        chk_rd(8'h40, "R2");
        chk_rd(8'h41, "R2");

        // random mix
        for (int it = 0; it < 1500; it++) begin
            if ($urandom_range(3) == 0)
                src_lvl = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                          & {$urandom, $urandom, $urandom};
            else
                src_lvl = '0;
            a = ($urandom_range(15) == 0) ? 8'($urandom) : ADDRS[$urandom_range(14)];
            d = $urandom;
            if (a == 8'h08) d = {31'd0, d[0]};
            cyc($urandom_range(1) == 1, a, d, $urandom_range(1) == 1);
            chk_rd(ADDRS[$urandom_range(14)], "R6");
            chk_rd(8'h00, "R6");
            chk_irq("R7");
        end

        finish_run();
    end

endmodule